// File: doc/BRIEF.md
# Real-Time Counter and Watchdog with Shared Prescaler

This block combines an 8-bit real-time counter and a watchdog timer for a small microcontroller core. A single programmable power-of-two prescaler sits in front of one of the two. A 6-bit mode word, loaded from the core's working register, controls four things: the counter's clock source (instruction cycle or an edge on an external pin), the pin edge polarity, which side owns the prescaler, and the division ratio. The counter divides by 2 to 256, and the watchdog by 1 to 128.

The core reads and writes the counter directly. It clears the watchdog with a clear-watchdog pulse or by entering sleep. The watchdog advances on a separate tick enable that stands in for its free-running RC oscillator, and it keeps running during sleep. When it expires, the block emits a one-cycle reset pulse, puts the mode word back to its reset value, and records in two flags what caused the reset. A timeout during sleep also wakes the core.

Top module: `rtc_wdt_prescale`

## Requirements
- R1: After power-on reset the mode word is 0x3F, the counter is 0, the power flag and the timeout flag are both 1, the block is awake, and the reset pulse is low.
- R2: A mode write loads bits [5:0] on the next edge. The fields are: [2:0] ratio code `ps`, [3] prescaler owner (0 = counter, 1 = watchdog), [4] pin polarity (0 = rising, 1 = falling), [5] counter source (0 = instruction cycle, 1 = pin).
- R3: When the counter owns no prescaler and uses the instruction-cycle source, it increments once for each cycle with `cyc_en` high and wraps from 0xFF to 0x00.
- R4: When the counter owns the prescaler, it increments once for every 2^(ps+1) source events.
- R5: With the pin source selected, a pin transition of the selected polarity increments the counter, or feeds the prescaler, at the third rising clock edge after the pin first shows the new level at a clock edge. Transitions of the other polarity are ignored.
- R6: A counter write loads the counter on the next edge, overrides any increment in that cycle, and clears the prescaler count.
- R7: The watchdog expires on its 2^WDT_W-th advance. It advances on every tick when the counter owns the prescaler, and once every 2^ps ticks when the watchdog owns it.
- R8: A clear-watchdog pulse or a sleep pulse sets the watchdog count and the prescaler count to zero.
- R9: On expiry, `wdt_rst` is high for exactly one cycle starting the next edge, the mode word becomes 0x3F, and the timeout flag becomes 0. The power flag becomes 1 if the block was awake.
- R10: While asleep the counter does not advance but the watchdog does. An expiry during sleep clears both flags to 0 and wakes the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cyc_en | input | 1 | Instruction-cycle enable |
| t_pin | input | 1 | External counter pin, asynchronous |
| wdt_tick | input | 1 | Watchdog oscillator tick enable |
| mode_we | input | 1 | Load mode word |
| mode_wdata | input | 6 | Mode word from the working register |
| cnt_we | input | 1 | Write counter |
| cnt_wdata | input | CNT_W | Counter write data |
| clr_wdt | input | 1 | Clear watchdog pulse |
| sleep_req | input | 1 | Enter sleep pulse |
| cnt_q | output | CNT_W | Counter value |
| mode_q | output | 6 | Mode word |
| tf | output | 1 | Timeout flag (0 after a watchdog expiry) |
| pf | output | 1 | Power flag |
| wdt_rst | output | 1 | Watchdog reset pulse |
| sleeping | output | 1 | Block is in sleep |

## Verification
The assertions check several properties on every cycle. The reset pulse lasts a single cycle, and every expiry leaves the mode word at 0x3F with the timeout flag low. A counter write always lands. A clear or sleep pulse always empties the watchdog and prescaler. The counter stays frozen while asleep. Only the bench's scenarios can show the remaining behaviour: the division ratios for each owner, the pin polarity and its three-edge latency, counter wrap-around, and the flag values that separate an awake expiry from a sleeping one. A behavioural model compares against these on every clock.

// File: rtl/rtc_wdt_prescale.sv
module rtc_wdt_prescale #(
  parameter int CNT_W = 8,
  parameter int WDT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             t_pin,
  input  logic             wdt_tick,
  input  logic             mode_we,
  input  logic [5:0]       mode_wdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             clr_wdt,
  input  logic             sleep_req,
  output logic [CNT_W-1:0] cnt_q,
  output logic [5:0]       mode_q,
  output logic             tf,
  output logic             pf,
  output logic             wdt_rst,
  output logic             sleeping
);
  localparam int PSC_W = 8;
  localparam logic [5:0] MODE_RST = 6'h3F;

  logic [PSC_W-1:0] psc;
  logic [WDT_W-1:0] wdt_cnt;
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b000;
    else        {s1, s2, s3} <= {t_pin, s1, s2};

  wire       psa    = mode_q[3];
  wire [3:0] shift  = psa ? {1'b0, mode_q[2:0]} : {1'b0, mode_q[2:0]} + 4'd1;
  wire [PSC_W-1:0] pmask = PSC_W'((32'd1 << shift) - 32'd1);

  wire pin_evt = mode_q[4] ? (s3 & ~s2) : (s2 & ~s3);
  wire src_evt = ~sleeping & (mode_q[5] ? pin_evt : cyc_en);
  wire psc_in  = psa ? wdt_tick : src_evt;
  wire psc_hit = psc_in & ((psc & pmask) == pmask);
  wire cnt_inc = psa ? src_evt : psc_hit;
  wire wdt_inc = psa ? psc_hit : wdt_tick;
  wire wdt_to  = wdt_inc & (&wdt_cnt);
  wire wdt_clr = clr_wdt | sleep_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_we)  cnt_q <= cnt_wdata;
    else if (cnt_inc) cnt_q <= cnt_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          psc <= '0;
    else if (wdt_to | wdt_clr | cnt_we)  psc <= '0;
    else if (psc_in)                     psc <= psc + PSC_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                wdt_cnt <= '0;
    else if (wdt_to | wdt_clr) wdt_cnt <= '0;
    else if (wdt_inc)          wdt_cnt <= wdt_cnt + WDT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode_q <= MODE_RST;
    else if (wdt_to)  mode_q <= MODE_RST;
    else if (mode_we) mode_q <= mode_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sleeping <= 1'b0;
      tf       <= 1'b1;
      pf       <= 1'b1;
      wdt_rst  <= 1'b0;
    end else begin
      wdt_rst <= wdt_to;
      if (wdt_to) begin
        sleeping <= 1'b0;
        tf       <= 1'b0;
        pf       <= ~sleeping;
      end else if (sleep_req) begin
        sleeping <= 1'b1;
      end
    end

  p_rst_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  p_mode_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (mode_q == MODE_RST && !tf));
  p_cnt_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt_q == $past(cnt_wdata));
  p_wdt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> (wdt_cnt == '0 && psc == '0));
  p_sleep_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !cnt_we) |=> cnt_q == $past(cnt_q));
  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst && $past(sleeping)) |-> (!sleeping && !pf));
endmodule

// File: tb/rtc_wdt_prescale_tb.sv
module rtc_wdt_prescale_tb;
  localparam int CNT_W = 8;
  localparam int WDT_W = 8;
  localparam int WDT_MAX = (1 << WDT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic cyc_en = 0, t_pin = 0, wdt_tick = 0;
  logic mode_we = 0, cnt_we = 0, clr_wdt = 0, sleep_req = 0;
  logic [5:0] mode_wdata = 0;
  logic [CNT_W-1:0] cnt_wdata = 0;
  logic [CNT_W-1:0] cnt_q;
  logic [5:0] mode_q;
  logic tf, pf, wdt_rst, sleeping;

  always #5 clk = ~clk;

  rtc_wdt_prescale #(.CNT_W(CNT_W), .WDT_W(WDT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .t_pin(t_pin), .wdt_tick(wdt_tick),
    .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .clr_wdt(clr_wdt), .sleep_req(sleep_req), .cnt_q(cnt_q), .mode_q(mode_q),
    .tf(tf), .pf(pf), .wdt_rst(wdt_rst), .sleeping(sleeping));

  int n_chk = 0, n_fail = 0;
  string req = "R1";
  bit chk_en = 0;

  // behavioural reference
  int m_cnt = 0, m_pe = 0, m_wdt = 0, divv = 1;
  logic [5:0] m_mode = 6'h3F;
  bit m_sleep = 0, m_tf = 1, m_pf = 1, m_wrst = 0;
  bit hist[$] = '{1'b0, 1'b0, 1'b0};
  bit edg, src, pin_in, pass, c_inc, w_inc, to;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 6'h3F; m_cnt = 0; m_pe = 0; m_wdt = 0;
      m_sleep = 0; m_tf = 1; m_pf = 1; m_wrst = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      edg = m_mode[4] ? (hist[2] && !hist[1]) : (hist[1] && !hist[2]);
      src = !m_sleep && (m_mode[5] ? edg : cyc_en);
      divv = m_mode[3] ? (1 << m_mode[2:0]) : (2 << m_mode[2:0]);
      pin_in = m_mode[3] ? wdt_tick : src;
      pass = pin_in && ((m_pe % divv) == divv - 1);
      c_inc = m_mode[3] ? src : pass;
      w_inc = m_mode[3] ? pass : wdt_tick;
      to = w_inc && (m_wdt == WDT_MAX);
      m_cnt = cnt_we ? int'(cnt_wdata) : (m_cnt + int'(c_inc)) % 256;
      m_wrst = to;
      if (to) begin
        m_mode = 6'h3F; m_wdt = 0; m_pe = 0;
        m_tf = 0; m_pf = !m_sleep; m_sleep = 0;
      end else begin
        if (mode_we) m_mode = mode_wdata;
        if (clr_wdt || sleep_req) begin m_wdt = 0; m_pe = 0; end
        else begin
          m_wdt = m_wdt + int'(w_inc);
          if (cnt_we) m_pe = 0; else m_pe = m_pe + int'(pin_in);
        end
        if (sleep_req) m_sleep = 1;
      end
      hist.push_front(t_pin);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) if (chk_en) begin
    n_chk++;
    if (cnt_q !== m_cnt[7:0] || mode_q !== m_mode || tf !== m_tf || pf !== m_pf ||
        wdt_rst !== m_wrst || sleeping !== m_sleep) begin
      n_fail++;
      $display("FAIL %s: cnt=%h/%h mode=%h/%h tf=%b/%b pf=%b/%b rst=%b/%b slp=%b/%b (actual/expected)",
        req, cnt_q, m_cnt[7:0], mode_q, m_mode, tf, m_tf, pf, m_pf, wdt_rst, m_wrst, sleeping, m_sleep);
    end
  end

  task automatic step(int n); repeat (n) @(negedge clk); endtask
  task automatic set_mode(logic [5:0] v);
    mode_we = 1; mode_wdata = v; step(1); mode_we = 0;
  endtask
  task automatic wr_cnt(logic [7:0] v);
    cnt_we = 1; cnt_wdata = v; step(1); cnt_we = 0;
  endtask
  task automatic pulse_clr; clr_wdt = 1; step(1); clr_wdt = 0; endtask
  task automatic explicit(string r, bit ok, int act, int exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: actual %0d expected %0d", r, act, exp); end
  endtask

  initial begin
    step(3); rst_n = 1; chk_en = 1;
    // R1 reset state
    req = "R1"; step(4);
    explicit("R1", mode_q == 6'h3F && tf && pf, mode_q, 63);
    // R2 mode load: internal source, prescaler to watchdog, ratio 0
    req = "R2"; set_mode(6'h08); step(2);
    explicit("R2", mode_q == 6'h08, mode_q, 8);
    // R3 plain counting with gaps and wrap
    req = "R3"; wr_cnt(8'hFA);
    for (int i = 0; i < 30; i++) begin cyc_en = (i % 3 != 1); step(1); end
    cyc_en = 1; step(10);
    // R4 prescaler to counter, 1:8 then 1:256
    req = "R4"; set_mode(6'h02); wr_cnt(8'h00); step(80);
    set_mode(6'h07); wr_cnt(8'h10); step(700);
    explicit("R4", cnt_q == 8'h12, cnt_q, 18);
    cyc_en = 0;
    // R5 pin source, rising then falling, then through prescaler 1:2
    req = "R5"; set_mode(6'h28); wr_cnt(8'h00);
    for (int i = 0; i < 60; i++) begin if (i % 3 == 0) t_pin = ~t_pin; step(1); end
    step(4);
    explicit("R5", cnt_q == 8'd10, cnt_q, 10);
    set_mode(6'h38);
    for (int i = 0; i < 60; i++) begin if (i % 4 == 0) t_pin = ~t_pin; step(1); end
    set_mode(6'h20);
    for (int i = 0; i < 60; i++) begin if (i % 2 == 0) t_pin = ~t_pin; step(1); end
    t_pin = 0; step(4); set_mode(6'h08);
    // R6 write beats a pending increment
    req = "R6"; cyc_en = 1; step(3); wr_cnt(8'h55);
    explicit("R6", cnt_q == 8'h55, cnt_q, 85);
    set_mode(6'h01); step(3); wr_cnt(8'hA0); step(6); cyc_en = 0;
    // R7/R9 awake expiry, counter owns prescaler
    req = "R7"; set_mode(6'h02); pulse_clr; wdt_tick = 1; step(250);
    req = "R9"; step(20); wdt_tick = 0; step(2);
    explicit("R9", !tf && pf && mode_q == 6'h3F, {tf, pf}, 1);
    // R7 watchdog owns prescaler at 1:2
    req = "R7"; set_mode(6'h09); pulse_clr; wdt_tick = 1; step(530); wdt_tick = 0; step(2);
    // R8 periodic clears prevent expiry
    req = "R8"; set_mode(6'h02); pulse_clr; wdt_tick = 1;
    for (int i = 0; i < 8; i++) begin step(200); pulse_clr; end
    explicit("R8", tf == 0 && mode_q == 6'h02, mode_q, 2);
    wdt_tick = 0;
    // R10 sleep freezes counter, expiry wakes with both flags low
    req = "R10"; set_mode(6'h00); cyc_en = 1; step(5);
    sleep_req = 1; step(1); sleep_req = 0; wdt_tick = 1; step(262);
    explicit("R10", !sleeping && !tf && !pf, {tf, pf}, 0);
    wdt_tick = 0; cyc_en = 0; step(5);
    chk_en = 0;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule